// File: doc/BRIEF.md
# Debug halt-inject-resume sequencer

This block takes a processor core through a fixed debug session without any external debugger. On a start pulse it asks the core to halt and waits until the core reports that it has halted. It then writes a seed value into the core's debug scratch register. Next it pushes a short program into the core, one 32-bit word at a time, over a valid/ready injection channel. That program reads the scratch register into a0, adds an immediate, and writes a0 back. It then pushes an all-zero word, which is illegal, and waits for the core's exception report. After that it pushes ebreak and waits for the core's ebreak report.

After the ebreak report it reads the scratch register back and compares the value with the seed plus the sign-extended immediate. It then pulses a resume request and waits for the core to report running again. At that point it raises done, with pass showing whether the readback matched. Every wait is guarded by a cycle limit. If any wait runs out, the sequence ends with done and timeout both set.

Top module: `dbg_seq`

## Requirements
- R1: After start is seen in an idle or finished state, halt_req goes high and stays high until halted is sampled high; in the cycle after that sample halt_req is low.
- R2: Once halted, d0_wen is high for exactly one cycle with d0_wdata equal to DATA0_INIT (default 123), and d0_wen is low in the cycle that follows.
- R3: While inj_vld is high and inj_rdy is low, inj_vld stays high and inj_data stays unchanged in the next cycle; a word counts as accepted only in a cycle with both high.
- R4: The accepted words come in this order: 0x7b202573, then the addi word {ADD_IMM, 5'd10, 3'b000, 5'd10, 7'h13} (0x1c850513 for the default 456), then 0x7b251073, then 0x00000000, then ebreak 0x00100073.
- R5: After the zero word is accepted, inj_vld stays low until caught_exc is sampled high; a caught_ebreak pulse in that wait has no effect, so the ebreak word is not presented before the exception pulse.
- R6: After ebreak is accepted, inj_vld drops and the block waits for caught_ebreak. It then captures d0_rdata into result. pass is set exactly when result equals DATA0_INIT plus the sign-extended ADD_IMM (579 by default).
- R7: After the readback, resume_req is high for exactly one cycle; done rises once running is sampled high, with timeout low.
- R8: If any wait (halted, inj_rdy, caught_exc, caught_ebreak, running) goes unmet for TIMEOUT cycles, the block ends with done=1, timeout=1 and pass=0, with all request, valid and write-enable outputs low.
- R9: Reset leaves the block idle with halt_req, resume_req, d0_wen, inj_vld, done, pass and timeout all low; done holds until the next start, and the next start clears done, pass and timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a session when idle or finished |
| halt_req | output | 1 | Halt request to the core |
| halted | input | 1 | Core reports halted |
| resume_req | output | 1 | One-cycle resume request |
| running | input | 1 | Core reports running |
| d0_wdata | output | 32 | Scratch register write data |
| d0_wen | output | 1 | Scratch register write enable |
| d0_rdata | input | 32 | Scratch register read data |
| inj_data | output | 32 | Injected instruction word |
| inj_vld | output | 1 | Injected word valid |
| inj_rdy | input | 1 | Core accepts the injected word |
| caught_ebreak | input | 1 | Core pulse: ebreak reached in debug mode |
| caught_exc | input | 1 | Core pulse: exception in debug mode |
| done | output | 1 | Session finished (success or timeout) |
| pass | output | 1 | Readback matched the expected sum |
| timeout | output | 1 | Session aborted on a wait limit |
| result | output | 32 | Scratch register value read back |

## Verification
The bench drives a behavioural core that really executes the injected words, with random ready stalls and random delays on its reports. A design that advanced on valid alone, or changed the word during a stall, would lose a word or execute the wrong one, and the scratch register would end up wrong. One run sends a stray ebreak pulse while the block waits for the exception. A block that accepts that pulse would present ebreak too early, and the order monitor catches that. Other runs corrupt the add inside the core, so pass must drop and result must read 580. Two runs never answer a wait, one in the halt phase and one in the exception phase. A limit that is off by a cycle, or missing, would show up in the done and timeout sampling around TIMEOUT cycles.

// File: rtl/dbg_seq.sv
module dbg_seq #(
  parameter int          TIMEOUT    = 1024,
  parameter logic [31:0] DATA0_INIT = 32'd123,
  parameter logic [11:0] ADD_IMM    = 12'd456
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        halt_req,
  input  logic        halted,
  output logic        resume_req,
  input  logic        running,
  output logic [31:0] d0_wdata,
  output logic        d0_wen,
  input  logic [31:0] d0_rdata,
  output logic [31:0] inj_data,
  output logic        inj_vld,
  input  logic        inj_rdy,
  input  logic        caught_ebreak,
  input  logic        caught_exc,
  output logic        done,
  output logic        pass,
  output logic        timeout,
  output logic [31:0] result
);
  localparam int          CW       = $clog2(TIMEOUT + 1);
  localparam logic [31:0] W_CSRR   = 32'h7b20_2573;
  localparam logic [31:0] W_ADDI   = {ADD_IMM, 5'd10, 3'b000, 5'd10, 7'h13};
  localparam logic [31:0] W_CSRW   = 32'h7b25_1073;
  localparam logic [31:0] W_EBREAK = 32'h0010_0073;
  localparam logic [31:0] EXPECT   = DATA0_INIT + {{20{ADD_IMM[11]}}, ADD_IMM};

  typedef enum logic [3:0] {
    S_IDLE, S_HALT, S_WR, S_INJ, S_WEXC, S_EBRK, S_WEBK,
    S_READ, S_RES, S_WRUN, S_DONE, S_FAIL
  } st_t;

  st_t           st, nx;
  logic [1:0]    idx;
  logic [CW-1:0] cnt;
  logic          is_wait, go, expired;
  logic [31:0]   word;

  assign is_wait = st inside {S_HALT, S_INJ, S_WEXC, S_EBRK, S_WEBK, S_WRUN};

  always_comb begin
    case (st)
      S_HALT:        go = halted;
      S_INJ, S_EBRK: go = inj_rdy;
      S_WEXC:        go = caught_exc;
      S_WEBK:        go = caught_ebreak;
      S_WRUN:        go = running;
      default:       go = 1'b0;
    endcase
  end

  assign expired = is_wait && !go && (cnt == CW'(TIMEOUT - 1));

  always_comb begin
    case (idx)
      2'd0:    word = W_CSRR;
      2'd1:    word = W_ADDI;
      2'd2:    word = W_CSRW;
      default: word = 32'h0;
    endcase
  end

  always_comb begin
    nx = st;
    if (expired) nx = S_FAIL;
    else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL: if (start) nx = S_HALT;
        S_HALT: if (go) nx = S_WR;
        S_WR:   nx = S_INJ;
        S_INJ:  if (go && idx == 2'd3) nx = S_WEXC;
        S_WEXC: if (go) nx = S_EBRK;
        S_EBRK: if (go) nx = S_WEBK;
        S_WEBK: if (go) nx = S_READ;
        S_READ: nx = S_RES;
        S_RES:  nx = S_WRUN;
        S_WRUN: if (go) nx = S_DONE;
        default: nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      cnt    <= '0;
      pass   <= 1'b0;
      result <= '0;
    end else begin
      st  <= nx;
      cnt <= (!is_wait || go) ? '0 : cnt + 1'b1;
      if (st == S_WR) idx <= '0;
      else if (st == S_INJ && inj_rdy) idx <= idx + 1'b1;
      if (nx == S_HALT && st != S_HALT) pass <= 1'b0;
      if (st == S_READ) begin
        result <= d0_rdata;
        pass   <= (d0_rdata == EXPECT);
      end
    end
  end

  assign halt_req   = (st == S_HALT);
  assign d0_wen     = (st == S_WR);
  assign d0_wdata   = DATA0_INIT;
  assign inj_vld    = (st == S_INJ) || (st == S_EBRK);
  assign inj_data   = (st == S_EBRK) ? W_EBREAK : word;
  assign resume_req = (st == S_RES);
  assign done       = (st == S_DONE) || (st == S_FAIL);
  assign timeout    = (st == S_FAIL);
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halt_req,
  input logic        halted,
  input logic        resume_req,
  input logic        d0_wen,
  input logic [31:0] inj_data,
  input logic        inj_vld,
  input logic        inj_rdy,
  input logic        done,
  input logic        pass,
  input logic        timeout
);
  a_r1_halt_drop: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && halted |=> !halt_req);

  a_r2_wen_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    d0_wen |=> !d0_wen && inj_vld);

  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    inj_vld && !inj_rdy |=> (inj_vld && $stable(inj_data)) || timeout);

  a_r7_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |=> !resume_req);

  a_r8_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done && !pass && !halt_req && !inj_vld && !d0_wen && !resume_req);

  a_r9_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, d0_wen, inj_vld, resume_req, done}));
endmodule

bind dbg_seq dbg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halted(halted),
  .resume_req(resume_req), .d0_wen(d0_wen), .inj_data(inj_data),
  .inj_vld(inj_vld), .inj_rdy(inj_rdy), .done(done), .pass(pass),
  .timeout(timeout)
);

// File: tb/dbg_seq_tb.sv
module dbg_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic halt_req, halted, resume_req, running, d0_wen, inj_vld, inj_rdy;
  logic caught_ebreak, caught_exc, done, pass, timeout;
  logic [31:0] d0_wdata, d0_rdata, inj_data, result;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_seq #(.TIMEOUT(TMO)) dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] data0, a0;
  assign d0_rdata = data0;

  bit m_nohalt, m_noexc, m_corrupt, m_spur;
  int hcnt, rcnt, ecnt, bcnt, scnt;
  bit rpend, epend, bpend, spend, exc_given;
  int n_words, n_wen, n_res, v_halt, v_wen, v_hold, v_res, v_order;
  logic [31:0] got [0:7];
  bit p_hh, p_wen, p_stall, p_res;
  logic [31:0] p_data;

  function automatic logic [31:0] exp_word(int i);
    case (i)
      0: return 32'h7b202573;
      1: return {12'd456, 5'd10, 3'b000, 5'd10, 7'h13};
      2: return 32'h7b251073;
      3: return 32'h0;
      default: return 32'h00100073;
    endcase
  endfunction

  function automatic logic [31:0] exp_result(bit corrupt);
    return 32'd123 + 32'd456 + (corrupt ? 32'd1 : 32'd0);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (p_hh && halt_req) v_halt++;
    if (p_wen && d0_wen) v_wen++;
    if (p_stall && !timeout && (!inj_vld || inj_data != p_data)) v_hold++;
    if (p_res && resume_req) v_res++;
    if (resume_req) n_res++;
    if (d0_wen) begin n_wen++; if (d0_wdata == 32'd123) data0 = d0_wdata; end
    caught_exc = 1'b0;
    caught_ebreak = 1'b0;
    if (halt_req && !halted && !m_nohalt) begin
      if (hcnt == 0) begin halted = 1'b1; running = 1'b0; end else hcnt--;
    end
    if (resume_req) begin halted = 1'b0; rpend = 1'b1; rcnt = $urandom % 5; end
    else if (rpend) begin
      if (rcnt == 0) begin running = 1'b1; rpend = 1'b0; end else rcnt--;
    end
    if (spend) begin
      if (scnt == 0) begin caught_ebreak = 1'b1; spend = 1'b0; end else scnt--;
    end else if (epend) begin
      if (ecnt == 0) begin caught_exc = 1'b1; epend = 1'b0; exc_given = 1'b1; end else ecnt--;
    end
    if (bpend) begin
      if (bcnt == 0) begin caught_ebreak = 1'b1; bpend = 1'b0; end else bcnt--;
    end
    if (inj_vld && inj_data == 32'h00100073 && !exc_given) v_order++;
    inj_rdy = ($urandom % 3) != 0;
    if (inj_vld && inj_rdy) begin
      if (n_words < 8) got[n_words] = inj_data;
      n_words++;
      if (inj_data == 32'h7b202573) a0 = data0;
      else if (inj_data[6:0] == 7'h13)
        a0 = a0 + {{20{inj_data[31]}}, inj_data[31:20]} + (m_corrupt ? 32'd1 : 32'd0);
      else if (inj_data == 32'h7b251073) data0 = a0;
      else if (inj_data == 32'h0) begin
        epend = !m_noexc; ecnt = 2 + $urandom % 5;
        if (m_spur) begin spend = 1'b1; scnt = 1; ecnt = ecnt + 3; end
      end else if (inj_data == 32'h00100073) begin bpend = 1'b1; bcnt = 1 + $urandom % 4; end
    end
    p_hh = halt_req && halted;
    p_wen = d0_wen;
    p_stall = inj_vld && !inj_rdy;
    p_data = inj_data;
    p_res = resume_req;
  end

  task automatic prep(bit nh, bit ne, bit co, bit sp);
    m_nohalt = nh; m_noexc = ne; m_corrupt = co; m_spur = sp;
    hcnt = $urandom % 6; halted = 1'b0; running = 1'b1;
    rpend = 0; epend = 0; bpend = 0; spend = 0; exc_given = 0;
    n_words = 0; n_wen = 0; n_res = 0;
    v_halt = 0; v_wen = 0; v_hold = 0; v_res = 0; v_order = 0;
    data0 = $urandom; a0 = 0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic full_run(bit co, bit sp);
    prep(0, 0, co, sp);
    kick();
    chk(!done && !pass && !timeout, "R9 start clears done", done, 0);
    wait_done();
    chk(done == 1'b1, "R7 done", done, 1);
    chk(timeout == 1'b0, "R7 no timeout", timeout, 0);
    chk(result == exp_result(co), "R6 result", result, exp_result(co));
    chk(pass == !co, "R6 pass", pass, !co);
    chk(n_words == 5, "R4 word count", n_words, 5);
    for (int i = 0; i < 5; i++)
      chk(got[i] == exp_word(i), "R4 word order", got[i], exp_word(i));
    chk(v_halt == 0, "R1 halt drop", v_halt, 0);
    chk(n_wen == 1 && v_wen == 0, "R2 wen pulse", n_wen, 1);
    chk(v_hold == 0, "R3 hold under stall", v_hold, 0);
    chk(v_order == 0, "R5 ebreak after exception", v_order, 0);
    chk(n_res == 1 && v_res == 0, "R7 resume pulse", n_res, 1);
  endtask

  initial begin
    void'($urandom(7));
    inj_rdy = 1'b0; halted = 1'b0; running = 1'b1;
    caught_exc = 1'b0; caught_ebreak = 1'b0; data0 = 0;
    m_nohalt = 1; m_noexc = 0; m_corrupt = 0; m_spur = 0;
    p_hh = 0; p_wen = 0; p_stall = 0; p_res = 0; p_data = 0;
    repeat (3) @(negedge clk);
    chk(!halt_req && !resume_req && !d0_wen && !inj_vld && !done && !pass && !timeout,
        "R9 reset state", {halt_req, resume_req, d0_wen, inj_vld, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!halt_req && !done, "R9 idle without start", halt_req, 0);

    for (int r = 0; r < 4; r++) full_run(0, 0);
    full_run(0, 1);
    full_run(1, 0);
    full_run(0, 0);

    prep(1, 0, 0, 0);
    kick();
    repeat (TMO - 3) @(negedge clk);
    chk(!done && halt_req, "R8 no early timeout", done, 0);
    repeat (5) @(negedge clk);
    chk(done && timeout && !pass, "R8 halt timeout", {done, timeout, pass}, 3'b110);
    chk(!halt_req && !inj_vld && !d0_wen && !resume_req, "R8 outputs quiet", halt_req, 0);

    prep(0, 1, 0, 0);
    kick();
    wait_done();
    chk(done && timeout && !pass, "R8 exception timeout", {done, timeout, pass}, 3'b110);
    chk(n_words == 4, "R5 no ebreak without exception", n_words, 4);

    full_run(0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule